// File: doc/BRIEF.md
# Descriptor-List Stream DMA Engine

This block moves the audio data of one stream between a codec-side transfer request and system memory. Memory is described by a list of buffer descriptors. Each descriptor is 16 bytes long and gives a 64-bit buffer address, a byte length and a flag word. When software sets the run bit, the engine fetches the list into a local table. After that it answers codec transfer requests. It tracks three things: the current entry, the byte offset inside that entry, and a link position that counts bytes around a cyclic buffer of programmable length.

Each codec request carries a stream tag, a direction and a byte count. The request is served only by a running stream whose tag and direction both match. The engine splits the request into memory data operations, each one limited by the cyclic buffer and by the current entry. When an entry whose flag asks for it is finished, the engine raises a completion status and interrupt. It then moves no more data until software writes one to clear the status. After each served request, the engine can optionally write the link position to a position buffer in memory.

Top module: `sdma_stream`

## Requirements
- R1: After `rst_n` is low, the control word (register 0) reads 0, the link position (register 1) reads 0, `irq` is low and `mem_req` is low. The register map is: 0 control, 1 link position (read-only), 2 cyclic length, 3 last index, 4/5 list base low/high (low 7 bits read 0), 6/7 position base low/high.
- R2: A 0-to-1 change of run (control bit 1) fetches last-index+1 descriptors with word reads (`mem_op` 0). The reads start at the list base, 16 bytes per descriptor, and go in this order: address low, address high, length, flags.
- R3: A request is served only when the tag equals control bits 23:20, `xfer_out` equals the stream direction, and the list is loaded. Any other request finishes with `xfer_ok`=0, `xfer_count`=0, no data operation and an unchanged link position.
- R4: Each data operation (`mem_op` 2 reads memory for an output stream, 3 writes it for an input stream) has address = entry address + entry offset. Its length is the smallest of: the remaining request bytes, cyclic length minus link position, and entry length minus entry offset.
- R5: When an entry is fully consumed, the offset returns to 0 and the entry index advances. After the last index, the index wraps to 0.
- R6: The link position returns to 0 when it reaches the cyclic length, and a request continues past that wrap.
- R7: Finishing an entry whose flags bit 0 is set raises the status (control bit 26) and `irq`. The request ends there, and `xfer_count` reports only the bytes moved up to that point.
- R8: While the status is set, requests are refused and no data moves. Writing 1 to control bit 26 clears the status; writing 0 leaves it set.
- R9: If position base bit 0 is set, each served request ends with a word write (`mem_op` 1) of the link position to (base with bit 0 cleared) + 8*STREAM_INDEX. If bit 0 is clear, no such write happens.
- R10: While control bit 0 (stream reset) is set, the link position, entry index, entry offset and status are cleared, and the list must be fetched again by a new run edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Buffer-completion interrupt (mirrors status) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_op | output | 2 | 0 word read, 1 word write, 2 data read, 3 data write |
| mem_addr | output | 64 | Byte address of the operation |
| mem_len | output | 32 | Byte count (4 for word operations) |
| mem_wdata | output | 32 | Word write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 32 | Word read data, valid with `mem_ack` |
| xfer_req | input | 1 | Codec transfer request, held until `xfer_done` |
| xfer_tag | input | 4 | Stream tag of the request |
| xfer_out | input | 1 | 1 for playback (memory to codec) |
| xfer_len | input | 16 | Requested byte count |
| xfer_done | output | 1 | One-cycle completion of the request |
| xfer_ok | output | 1 | Request was served |
| xfer_count | output | 16 | Bytes moved for the request |

## Verification
The assertions assume that the cyclic length, last index and list base stay fixed while the stream runs. They also assume that memory acknowledges only a pending request and that a codec request is held until it is done. The bench programs these registers only while run is clear or before the run edge. Its memory model acknowledges each request once, one cycle after it appears, and it drops `xfer_req` on the cycle it sees `xfer_done`. The directed scenarios cover a chunk cut by the entry end, one cut by the cyclic wrap, a request spanning two entries, and the stall with its acknowledge.

// File: rtl/sdma_pkg.sv
// Shared types for the stream DMA engine.
// Assumes 64-bit memory addresses and 32-bit register words.
package sdma_pkg;
    localparam int WORD_W = 32;
    localparam int MADDR_W = 64;
    localparam int TAG_W = 4;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_LPOS = 3'd1;
    localparam logic [2:0] RA_CYC = 3'd2;
    localparam logic [2:0] RA_LAST = 3'd3;
    localparam logic [2:0] RA_LBLO = 3'd4;
    localparam logic [2:0] RA_LBHI = 3'd5;
    localparam logic [2:0] RA_PBLO = 3'd6;
    localparam logic [2:0] RA_PBHI = 3'd7;

    localparam int CB_SRST = 0;
    localparam int CB_RUN = 1;
    localparam int CB_TAGLO = 20;
    localparam int CB_STAT = 26;

    typedef enum logic [1:0] {
        MOP_FETCH = 2'd0,
        MOP_STORE = 2'd1,
        MOP_DRD = 2'd2,
        MOP_DWR = 2'd3
    } mop_e;

    typedef struct packed {
        logic [MADDR_W-1:0] addr;
        logic [WORD_W-1:0] len;
        logic ioc;
    } desc_t;
endpackage

// File: rtl/sdma_regs.sv
// Control and status registers of one stream.
// Holds run, stream reset, tag and the write-one-to-clear completion
// status, plus cyclic length, last index and the two base addresses.
// Assumes single-cycle write strobes; reads are combinational.
module sdma_regs
    import sdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reg_we,
    input  logic [2:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] link_pos,
    input  logic evt_stat_set,
    output logic run,
    output logic srst,
    output logic [TAG_W-1:0] tag,
    output logic status,
    output logic [WORD_W-1:0] cyc_len,
    output logic [7:0] last_idx,
    output logic [MADDR_W-1:0] list_base,
    output logic [MADDR_W-1:0] pos_base
);
    logic [24:0] lb_lo_q;
    logic [WORD_W-1:0] lb_hi_q, pb_lo_q, pb_hi_q;
    logic ctrl_wr;

    assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
    assign list_base = {lb_hi_q, lb_lo_q, 7'b0};
    assign pos_base = {pb_hi_q, pb_lo_q};

    // Register writes for control fields and programming registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            srst <= 1'b0;
            tag <= '0;
            cyc_len <= '0;
            last_idx <= '0;
            lb_lo_q <= '0;
            lb_hi_q <= '0;
            pb_lo_q <= '0;
            pb_hi_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    srst <= reg_wdata[CB_SRST];
                    run <= reg_wdata[CB_RUN];
                    tag <= reg_wdata[CB_TAGLO +: TAG_W];
                end
                RA_CYC: cyc_len <= reg_wdata;
                RA_LAST: last_idx <= reg_wdata[7:0];
                RA_LBLO: lb_lo_q <= reg_wdata[31:7];
                RA_LBHI: lb_hi_q <= reg_wdata;
                RA_PBLO: pb_lo_q <= reg_wdata;
                RA_PBHI: pb_hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Completion status: stream reset clears, engine event sets, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            status <= 1'b0;
        end else if (evt_stat_set) begin
            status <= 1'b1;
        end else if (ctrl_wr && reg_wdata[CB_STAT]) begin
            status <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata = '0;
                reg_rdata[CB_SRST] = srst;
                reg_rdata[CB_RUN] = run;
                reg_rdata[CB_TAGLO +: TAG_W] = tag;
                reg_rdata[CB_STAT] = status;
            end
            RA_LPOS: reg_rdata = link_pos;
            RA_CYC: reg_rdata = cyc_len;
            RA_LAST: reg_rdata = {24'b0, last_idx};
            RA_LBLO: reg_rdata = {lb_lo_q, 7'b0};
            RA_LBHI: reg_rdata = lb_hi_q;
            RA_PBLO: reg_rdata = pb_lo_q;
            default: reg_rdata = pb_hi_q;
        endcase
    end

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !srst && !(ctrl_wr && (reg_wdata[CB_STAT] || reg_wdata[CB_SRST])))
        |=> status) else $error("status lost without write-one"); // R8
endmodule

// File: rtl/sdma_desc_table.sv
// Local copy of the buffer descriptor list.
// One write port fed word by word during the list fetch (word 0 address
// low, 1 address high, 2 length, 3 flags) and one combinational read port.
module sdma_desc_table
    import sdma_pkg::*;
#(
    parameter int MAX_DESC = 8,
    localparam int IDX_W = $clog2(MAX_DESC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t rd_desc
);
    desc_t ent [MAX_DESC];

    for (genvar gi = 0; gi < MAX_DESC; gi++) begin : g_ent
        // Capture one field of entry gi during the fetch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                case (wr_word)
                    2'd0: ent[gi].addr[31:0] <= wr_data;
                    2'd1: ent[gi].addr[63:32] <= wr_data;
                    2'd2: ent[gi].len <= wr_data;
                    default: ent[gi].ioc <= wr_data[0];
                endcase
            end
        end
    end

    assign rd_desc = ent[rd_idx];
endmodule

// File: rtl/sdma_engine.sv
// Sequencer of the stream: fetches the descriptor list on run, serves
// codec requests chunk by chunk, tracks entry index, entry offset and
// link position, raises the completion event and writes the position buffer.
// Assumes cyclic length, last index and bases are stable while running,
// and mem_ack comes only while mem_req is high.
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int MAX_DESC = 8,
    parameter int STREAM_INDEX = 4,
    parameter bit IS_OUTPUT = 1'b1,
    parameter int XLEN_W = 16,
    localparam int IDX_W = $clog2(MAX_DESC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic srst,
    input  logic [TAG_W-1:0] tag,
    input  logic status,
    input  logic [WORD_W-1:0] cyc_len,
    input  logic [7:0] last_idx,
    input  logic [MADDR_W-1:0] list_base,
    input  logic [MADDR_W-1:0] pos_base,
    output logic [WORD_W-1:0] link_pos,
    output logic evt_stat_set,
    output logic tbl_we,
    output logic [IDX_W-1:0] tbl_widx,
    output logic [1:0] tbl_word,
    output logic [IDX_W-1:0] tbl_ridx,
    input  desc_t cur,
    output logic mem_req,
    output mop_e mem_op,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_len,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic mem_ack,
    input  logic xfer_req,
    input  logic [TAG_W-1:0] xfer_tag,
    input  logic xfer_out,
    input  logic [XLEN_W-1:0] xfer_len,
    output logic xfer_done,
    output logic xfer_ok,
    output logic [XLEN_W-1:0] xfer_count
);
    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_READY, S_CHUNK, S_POSW, S_DONE
    } st_e;

    localparam logic [7:0] MAX_LAST = 8'(MAX_DESC - 1);
    localparam logic [MADDR_W-1:0] POS_OFS = MADDR_W'(8 * STREAM_INDEX);

    st_e state;
    logic run_prev, loaded_q, ok_q;
    logic [IDX_W-1:0] ld_idx, ent_idx, last_eff, next_idx;
    logic [1:0] ld_word;
    logic [WORD_W-1:0] ent_off;
    logic [XLEN_W-1:0] left_q, moved_q, chunk_x;
    logic [WORD_W-1:0] cyc_rem, ent_rem, chunk, new_off, new_pos, left_ext;
    logic ent_end, hit, fin_pos, data_ack;

    assign last_eff = (last_idx > MAX_LAST) ? IDX_W'(MAX_DESC - 1) : last_idx[IDX_W-1:0];
    assign next_idx = (ent_idx == last_eff) ? '0 : ent_idx + 1'b1;
    assign hit = (xfer_tag == tag) && (xfer_out == IS_OUTPUT);
    assign fin_pos = pos_base[0];
    assign left_ext = WORD_W'(left_q);

    // Chunk size: smallest of request remainder, cyclic and entry remainders.
    always_comb begin
        cyc_rem = (link_pos < cyc_len) ? cyc_len - link_pos : '0;
        ent_rem = (ent_off < cur.len) ? cur.len - ent_off : '0;
        chunk = left_ext;
        if (cyc_rem < chunk) chunk = cyc_rem;
        if (ent_rem < chunk) chunk = ent_rem;
        chunk_x = chunk[XLEN_W-1:0];
        new_off = ent_off + chunk;
        new_pos = link_pos + chunk;
        ent_end = (new_off == cur.len);
    end

    assign data_ack = (state == S_CHUNK) && (chunk != '0) && mem_ack;
    assign evt_stat_set = data_ack && ent_end && cur.ioc;

    assign tbl_we = (state == S_LOAD) && mem_ack;
    assign tbl_widx = ld_idx;
    assign tbl_word = ld_word;
    assign tbl_ridx = ent_idx;

    // Memory request decode from the current state.
    always_comb begin
        mem_req = 1'b0;
        mem_op = MOP_FETCH;
        mem_addr = '0;
        mem_len = WORD_W'(4);
        mem_wdata = link_pos;
        case (state)
            S_LOAD: begin
                mem_req = 1'b1;
                mem_addr = list_base + MADDR_W'({ld_idx, ld_word, 2'b00});
            end
            S_CHUNK: begin
                mem_req = (chunk != '0);
                mem_op = IS_OUTPUT ? MOP_DRD : MOP_DWR;
                mem_addr = cur.addr + MADDR_W'(ent_off);
                mem_len = chunk;
            end
            S_POSW: begin
                mem_req = 1'b1;
                mem_op = MOP_STORE;
                mem_addr = {pos_base[MADDR_W-1:1], 1'b0} + POS_OFS;
            end
            default: ;
        endcase
    end

    assign xfer_done = (state == S_DONE);
    assign xfer_ok = ok_q;
    assign xfer_count = moved_q;

    // Sequencer: list fetch, request service, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            run_prev <= 1'b0;
            loaded_q <= 1'b0;
            ok_q <= 1'b0;
            ld_idx <= '0;
            ld_word <= '0;
            left_q <= '0;
            moved_q <= '0;
        end else begin
            run_prev <= run;
            case (state)
                S_IDLE: begin
                    if (run && !run_prev && !srst) begin
                        state <= S_LOAD;
                        ld_idx <= '0;
                        ld_word <= '0;
                    end else if (xfer_req) begin
                        ok_q <= 1'b0;
                        moved_q <= '0;
                        state <= S_DONE;
                    end
                end
                S_LOAD: begin
                    if (mem_ack) begin
                        ld_word <= ld_word + 1'b1;
                        if (ld_word == 2'd3) begin
                            if (ld_idx == last_eff) begin
                                state <= S_READY;
                                loaded_q <= 1'b1;
                            end else begin
                                ld_idx <= ld_idx + 1'b1;
                            end
                        end
                    end
                end
                S_READY: begin
                    if (srst || !run) begin
                        state <= S_IDLE;
                        loaded_q <= 1'b0;
                    end else if (xfer_req) begin
                        moved_q <= '0;
                        if (hit && !status) begin
                            left_q <= xfer_len;
                            ok_q <= 1'b1;
                            state <= S_CHUNK;
                        end else begin
                            ok_q <= 1'b0;
                            state <= S_DONE;
                        end
                    end
                end
                S_CHUNK: begin
                    if (chunk == '0) begin
                        state <= fin_pos ? S_POSW : S_DONE;
                    end else if (mem_ack) begin
                        left_q <= left_q - chunk_x;
                        moved_q <= moved_q + chunk_x;
                        if ((ent_end && cur.ioc) || (left_q == chunk_x)) begin
                            state <= fin_pos ? S_POSW : S_DONE;
                        end
                    end
                end
                S_POSW: if (mem_ack) state <= S_DONE;
                default: state <= loaded_q ? S_READY : S_IDLE;
            endcase
        end
    end

    // Position tracking: entry index, entry offset, link position.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            link_pos <= '0;
            ent_idx <= '0;
            ent_off <= '0;
        end else if (data_ack) begin
            ent_off <= ent_end ? '0 : new_off;
            ent_idx <= ent_end ? next_idx : ent_idx;
            link_pos <= (new_pos == cyc_len) ? '0 : new_pos;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !srst) |=> mem_req) else $error("request dropped"); // R4
    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_op == MOP_DRD || mem_op == MOP_DWR))
        |-> (mem_len != '0 && mem_len <= left_ext)) else $error("chunk too large"); // R4
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ent_idx <= last_eff) else $error("entry index past last"); // R5
    AST_POS_WRAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_ok && cyc_len != '0) |-> (link_pos < cyc_len))
        else $error("link position not wrapped"); // R6
    AST_NO_DATA_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        status |-> !(mem_req && (mem_op == MOP_DRD || mem_op == MOP_DWR)))
        else $error("data moved while stalled"); // R8
    AST_REFUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !xfer_ok) |-> (xfer_count == '0)) else $error("refused with bytes"); // R3
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (link_pos == '0)) else $error("stream reset ignored"); // R10
endmodule

// File: rtl/sdma_stream.sv
// Top of the single-stream descriptor DMA engine: registers, descriptor
// table and sequencer. irq follows the completion status.
module sdma_stream
    import sdma_pkg::*;
#(
    parameter int MAX_DESC = 8,
    parameter int STREAM_INDEX = 4,
    parameter bit IS_OUTPUT = 1'b1,
    parameter int XLEN_W = 16,
    localparam int IDX_W = $clog2(MAX_DESC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_we,
    input  logic [2:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic irq,
    output logic mem_req,
    output logic [1:0] mem_op,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_len,
    output logic [31:0] mem_wdata,
    input  logic mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic xfer_req,
    input  logic [3:0] xfer_tag,
    input  logic xfer_out,
    input  logic [XLEN_W-1:0] xfer_len,
    output logic xfer_done,
    output logic xfer_ok,
    output logic [XLEN_W-1:0] xfer_count
);
    logic run, srst, status, evt_stat_set, tbl_we;
    logic [TAG_W-1:0] tag;
    logic [WORD_W-1:0] cyc_len, link_pos;
    logic [7:0] last_idx;
    logic [MADDR_W-1:0] list_base, pos_base;
    logic [IDX_W-1:0] tbl_widx, tbl_ridx;
    logic [1:0] tbl_word;
    desc_t cur;
    mop_e op;

    assign irq = status;
    assign mem_op = op;

    sdma_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_pos(link_pos),
        .evt_stat_set(evt_stat_set), .run(run), .srst(srst), .tag(tag),
        .status(status), .cyc_len(cyc_len), .last_idx(last_idx),
        .list_base(list_base), .pos_base(pos_base)
    );

    sdma_desc_table #(.MAX_DESC(MAX_DESC)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_widx),
        .wr_word(tbl_word), .wr_data(mem_rdata), .rd_idx(tbl_ridx), .rd_desc(cur)
    );

    sdma_engine #(
        .MAX_DESC(MAX_DESC), .STREAM_INDEX(STREAM_INDEX),
        .IS_OUTPUT(IS_OUTPUT), .XLEN_W(XLEN_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .srst(srst), .tag(tag),
        .status(status), .cyc_len(cyc_len), .last_idx(last_idx),
        .list_base(list_base), .pos_base(pos_base), .link_pos(link_pos),
        .evt_stat_set(evt_stat_set), .tbl_we(tbl_we), .tbl_widx(tbl_widx),
        .tbl_word(tbl_word), .tbl_ridx(tbl_ridx), .cur(cur),
        .mem_req(mem_req), .mem_op(op), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .xfer_req(xfer_req),
        .xfer_tag(xfer_tag), .xfer_out(xfer_out), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .xfer_ok(xfer_ok), .xfer_count(xfer_count)
    );
endmodule

// File: tb/sdma_stream_tb.sv
// Directed bench for sdma_stream: one task per scenario.
module sdma_stream_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq, mem_req, mem_ack = 1'b0;
    logic [1:0] mem_op;
    logic [63:0] mem_addr;
    logic [31:0] mem_len, mem_wdata, mem_rdata = '0;
    logic xfer_req = 1'b0, xfer_out = 1'b1;
    logic [3:0] xfer_tag = '0;
    logic [15:0] xfer_len = '0, xfer_count;
    logic xfer_done, xfer_ok;

    always #4 clk = ~clk;

    sdma_stream u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .xfer_req(xfer_req), .xfer_tag(xfer_tag),
        .xfer_out(xfer_out), .xfer_len(xfer_len), .xfer_done(xfer_done),
        .xfer_ok(xfer_ok), .xfer_count(xfer_count)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] dmem [256];
    int fetch_n = 0, store_n = 0, d_n = 0;
    logic [63:0] fetch_last, st_addr;
    logic [31:0] st_data;
    logic [63:0] d_addr [64];
    logic [31:0] d_len [64];
    logic [1:0] d_op [64];
    localparam logic [31:0] CTL_RUN = 32'h0050_0002;

    // Memory model: acknowledge one cycle after a request, log every operation.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_rdata <= dmem[mem_addr[9:2]];
            case (mem_op)
                2'd0: begin fetch_n++; fetch_last = mem_addr; end
                2'd1: begin store_n++; st_addr = mem_addr; st_data = mem_wdata; end
                default: begin
                    d_addr[d_n[5:0]] = mem_addr; d_len[d_n[5:0]] = mem_len;
                    d_op[d_n[5:0]] = mem_op; d_n++;
                end
            endcase
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic xfer(input logic [3:0] t, input logic o, input logic [15:0] n,
                        output logic ok, output logic [15:0] cnt);
        @(negedge clk);
        xfer_tag = t; xfer_out = o; xfer_len = n; xfer_req = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (xfer_done) break;
        end
        ok = xfer_ok; cnt = xfer_count;
        xfer_req = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd1, v); chk("R1 linkpos", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_req", mem_req, 0);
    endtask

    task automatic t_load;
        wr(3'd2, 144); wr(3'd3, 2); wr(3'd4, 32'h100); wr(3'd5, 0);
        wr(3'd6, 32'h401); wr(3'd7, 0);
        wr(3'd0, CTL_RUN);
        repeat (40) @(negedge clk);
        chk("R2 fetch count", fetch_n, 12);
        chk("R2 last fetch addr", fetch_last, 64'h12C);
    endtask

    task automatic t_first;
        logic ok; logic [15:0] c; logic [31:0] v; int d0;
        d0 = d_n;
        xfer(4'd5, 1'b1, 16'd40, ok, c);
        chk("R4 ok", ok, 1); chk("R4 count", c, 40);
        chk("R4 ops", d_n - d0, 1);
        chk("R4 addr", d_addr[d0[5:0]], 64'h1000);
        chk("R4 len", d_len[d0[5:0]], 40);
        chk("R4 op is memory read", d_op[d0[5:0]], 2);
        rd(3'd1, v); chk("R4 linkpos", v, 40);
        chk("R9 store addr", st_addr, 64'h420);
        chk("R9 store data", st_data, 40);
    endtask

    task automatic t_refuse;
        logic ok; logic [15:0] c; logic [31:0] v; int d0;
        d0 = d_n;
        xfer(4'd6, 1'b1, 16'd8, ok, c);
        chk("R3 tag mismatch ok", ok, 0); chk("R3 tag mismatch count", c, 0);
        xfer(4'd5, 1'b0, 16'd8, ok, c);
        chk("R3 dir mismatch ok", ok, 0);
        chk("R3 no data op", d_n - d0, 0);
        rd(3'd1, v); chk("R3 linkpos kept", v, 40);
    endtask

    task automatic t_ioc_stop;
        logic ok; logic [15:0] c; logic [31:0] v; int d0;
        d0 = d_n;
        xfer(4'd5, 1'b1, 16'd40, ok, c);
        chk("R7 count cut at entry end", c, 24);
        chk("R4 entry-limited len", d_len[d0[5:0]], 24);
        chk("R4 offset addr", d_addr[d0[5:0]], 64'h1028);
        chk("R7 irq", irq, 1);
        rd(3'd0, v); chk("R7 status bit", v[26], 1);
        rd(3'd1, v); chk("R7 linkpos", v, 64);
    endtask

    task automatic t_stall_ack;
        logic ok; logic [15:0] c; logic [31:0] v; int d0;
        d0 = d_n;
        xfer(4'd5, 1'b1, 16'd16, ok, c);
        chk("R8 stalled ok", ok, 0);
        chk("R8 stalled no data", d_n - d0, 0);
        wr(3'd0, CTL_RUN);
        rd(3'd0, v); chk("R8 write 0 keeps status", v[26], 1);
        wr(3'd0, CTL_RUN | 32'h0400_0000);
        rd(3'd0, v); chk("R8 write 1 clears status", v[26], 0);
        chk("R8 irq low", irq, 0);
    endtask

    task automatic t_span;
        logic ok; logic [15:0] c; logic [31:0] v; int d0;
        d0 = d_n;
        xfer(4'd5, 1'b1, 16'd50, ok, c);
        chk("R5 count", c, 50);
        chk("R5 two ops", d_n - d0, 2);
        chk("R5 entry1 addr", d_addr[d0[5:0]], 64'h2000);
        chk("R5 entry1 len", d_len[d0[5:0]], 32);
        chk("R5 entry2 addr", d_addr[6'(d0 + 1)], 64'h3000);
        chk("R5 entry2 len", d_len[6'(d0 + 1)], 18);
        chk("R7 no irq without flag", irq, 0);
        rd(3'd1, v); chk("R5 linkpos", v, 114);
    endtask

    task automatic t_wrap;
        logic ok; logic [15:0] c; logic [31:0] v; int d0;
        d0 = d_n;
        xfer(4'd5, 1'b1, 16'd40, ok, c);
        chk("R6 count", c, 30);
        chk("R6 addr", d_addr[d0[5:0]], 64'h3012);
        rd(3'd1, v); chk("R6 linkpos wraps", v, 0);
        chk("R7 irq last entry", irq, 1);
        wr(3'd0, CTL_RUN | 32'h0400_0000);
        d0 = d_n;
        xfer(4'd5, 1'b1, 16'd10, ok, c);
        chk("R5 index wrapped addr", d_addr[d0[5:0]], 64'h1000);
        chk("R5 index wrapped len", d_len[d0[5:0]], 10);
    endtask

    task automatic t_posbuf_off;
        logic ok; logic [15:0] c; logic [31:0] v; int s0;
        wr(3'd6, 32'h400);
        s0 = store_n;
        xfer(4'd5, 1'b1, 16'd4, ok, c);
        chk("R9 served", ok, 1);
        chk("R9 no store when disabled", store_n - s0, 0);
        rd(3'd1, v); chk("R9 linkpos", v, 14);
    endtask

    task automatic t_srst_cyc;
        logic ok; logic [15:0] c; logic [31:0] v; int d0;
        xfer(4'd5, 1'b1, 16'd60, ok, c);
        chk("R10 setup count", c, 50);
        chk("R10 setup irq", irq, 1);
        wr(3'd0, 32'h0050_0001);
        rd(3'd1, v); chk("R10 linkpos cleared", v, 0);
        rd(3'd0, v); chk("R10 status cleared", v, 32'h0050_0001);
        chk("R10 irq low", irq, 0);
        wr(3'd2, 20);
        wr(3'd0, CTL_RUN);
        repeat (40) @(negedge clk);
        chk("R10 refetch", fetch_n, 24);
        d0 = d_n;
        xfer(4'd5, 1'b1, 16'd30, ok, c);
        chk("R6 count across wrap", c, 30);
        chk("R10 offset cleared addr", d_addr[d0[5:0]], 64'h1000);
        chk("R6 cyclic-limited len", d_len[d0[5:0]], 20);
        chk("R6 continues addr", d_addr[6'(d0 + 1)], 64'h1014);
        chk("R6 continues len", d_len[6'(d0 + 1)], 10);
        rd(3'd1, v); chk("R6 linkpos", v, 10);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = '0;
        dmem[64] = 32'h1000; dmem[66] = 64; dmem[67] = 1;
        dmem[68] = 32'h2000; dmem[70] = 32; dmem[71] = 0;
        dmem[72] = 32'h3000; dmem[74] = 48; dmem[75] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_load;
        t_first;
        t_refuse;
        t_ioc_stop;
        t_stall_ack;
        t_span;
        t_wrap;
        t_posbuf_off;
        t_srst_cyc;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule